// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit timer/counter that sits on a byte-wide register bus. Software can read and write the counter, the 16-bit capture/reload register, a main control register and a mode register. The counter advances on one of two sources. The first is a prescaled system clock tick: one tick every 12 clocks, or every 6 clocks when the fast-mode input is high. The second is a falling edge on an external count pin.

A second external pin, the trigger, is shared between several jobs. It can capture the counter, it can force a reload, or, in up/down mode, it sets the counting direction.

Two clock-select bits turn the block into a baud generator for a serial port. Each counter wrap then appears as a one-cycle pulse on the receive and/or transmit baud output. An interrupt request combines the overflow flag and the external-event flag.

Top module: `caprel_timer`

## Requirements
- R1: After reset the control register reads 00h, the mode register reads 00h, the counter and capture register read 0000h, `irq` is 0 and both baud outputs are 0.
- R2: Register addresses and layouts are fixed:
  - Control is at C8h. Its bits, from 7 down to 0, are: overflow flag, external flag, receive-clock select, transmit-clock select, external enable, run, source select (1 = external pin), capture select.
  - Mode is at C9h. Bit 1 is the clock-output enable and bit 0 is the up/down enable; bits 7..2 read 0.
  - The capture register's low and high bytes are at CAh and CBh. The counter's low and high bytes are at CCh and CDh.
  - Every one of these registers can be written and read back.
- R3: With run = 1 and source select = 0, the counter advances once every 12 clocks, or once every 6 clocks while `fast_mode` is high.
- R4: With run = 1 and source select = 1, the counter advances once per falling edge on `cnt_pin`. With run = 0 it holds its value. Both pins pass through a two-stage synchronizer.
- R5: In reload mode (capture select = 0, both clock selects 0, up/down off), a counter step from FFFFh loads the capture value and sets the overflow flag. The flag stays set until software writes it to 0.
- R6: `irq` is high whenever the overflow flag is set.
- R7: With the external enable set, a falling edge on `trig_pin` sets the external flag. In capture mode it copies the counter into the capture register and leaves the counter unchanged. In reload mode it loads the counter from the capture register.
- R8: With the external enable clear, a trigger falling edge changes neither the capture register, the counter nor the control register.
- R9: While either clock select is 1:
  - The counter reloads from the capture register after FFFFh, whatever the capture select says.
  - Each such wrap gives a one-cycle pulse on `rx_baud` (when the receive select is set) and on `tx_baud` (when the transmit select is set).
  - The overflow flag is never set.
  - A trigger edge neither captures nor reloads.
- R10: With up/down enabled, the trigger level sets the direction: high counts up, low counts down.
  - Counting up from FFFFh loads the capture value.
  - Counting down from the capture value loads FFFFh.
  - Both cases set the overflow flag, and a trigger edge does not capture or reload.
- R11: With up/down enabled, a set external flag does not raise `irq`. With up/down disabled, it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | Selects the divide-by-6 tick instead of divide-by-12 |
| cnt_pin | input | 1 | External count source, falling edge active |
| trig_pin | input | 1 | External trigger / direction input |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| rx_baud | output | 1 | Receive baud pulse |
| tx_baud | output | 1 | Transmit baud pulse |

## Verification
The assertions take several things for granted:
- The external pins stay at each level for at least one sampled clock, so the synchronizer sees every falling edge.
- `bus_we` is a single-cycle strobe with a stable address.
- The sticky-flag properties allow a flag to drop only in a cycle that carries a control write.

The stimulus keeps within these limits. It holds each pin low and then high for three clocks per event, and it changes inputs only on the falling clock edge. It writes counter values only while the chosen source is idle, so no count step lands on the same cycle as a software write.

// File: rtl/caprel_pkg.sv
package caprel_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'hC8;
  localparam logic [ADDR_W-1:0] A_MODE   = 8'hC9;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 8'hCA;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 8'hCB;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'hCC;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'hCD;

  // control register bit positions
  localparam int B_OVF  = 7;
  localparam int B_EXT  = 6;
  localparam int B_RXS  = 5;
  localparam int B_TXS  = 4;
  localparam int B_EXEN = 3;
  localparam int B_RUN  = 2;
  localparam int B_SRC  = 1;
  localparam int B_CAPT = 0;

  // mode register bit positions
  localparam int M_CKOE = 1;
  localparam int M_UPDN = 0;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    OP_RELOAD  = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_UPDOWN  = 2'd2,
    OP_BAUD    = 2'd3
  } op_mode_e;
endpackage

// File: rtl/caprel_edge_sync.sv
module caprel_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[STAGES-1];
  assign fall  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/caprel_prescaler.sv
module caprel_prescaler #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pc_q, pc_d, last;

  always_comb begin
    last = fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
    tick = run && (pc_q == last);
    if (!run || pc_q == last) pc_d = '0;
    else                      pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/caprel_core.sv
module caprel_core
  import caprel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_mode_e      mode,
  input  logic          step,
  input  logic          dir_up,
  input  logic          trig,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic          wr_cap_lo,
  input  logic          wr_cap_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] cnt,
  output logic [2*DW-1:0] cap,
  output logic          wrap
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic          full, at_cap;

  always_comb begin
    full   = (cnt_q == '1);
    at_cap = (cnt_q == cap_q);
    cnt_d  = cnt_q;
    cap_d  = cap_q;
    wrap   = 1'b0;
    unique case (mode)
      OP_BAUD: if (step) begin
        if (full) begin cnt_d = cap_q; wrap = 1'b1; end
        else cnt_d = cnt_q + 1'b1;
      end
      OP_UPDOWN: if (step) begin
        if (dir_up) begin
          if (full) begin cnt_d = cap_q; wrap = 1'b1; end
          else cnt_d = cnt_q + 1'b1;
        end else begin
          if (at_cap) begin cnt_d = '1; wrap = 1'b1; end
          else cnt_d = cnt_q - 1'b1;
        end
      end
      OP_CAPTURE: begin
        if (trig) cap_d = cnt_q;
        if (step) begin cnt_d = cnt_q + 1'b1; wrap = full; end
      end
      default: begin
        if (trig) cnt_d = cap_q;
        else if (step) begin
          if (full) begin cnt_d = cap_q; wrap = 1'b1; end
          else cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
    if (wr_cnt_lo) cnt_d[DW-1:0]  = wdata;
    if (wr_cnt_hi) cnt_d[CW-1:DW] = wdata;
    if (wr_cap_lo) cap_d[DW-1:0]  = wdata;
    if (wr_cap_hi) cap_d[CW-1:DW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cnt = cnt_q;
  assign cap = cap_q;

  // R4: no source step, no trigger, no write -> counter holds
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !trig && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == $past(cnt_q)));

  // R7: capture copies the counter value seen at the trigger
  p_capture_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OP_CAPTURE && trig && !wr_cap_lo && !wr_cap_hi) |=> (cap_q == $past(cnt_q)));
endmodule

// File: rtl/caprel_timer.sv
module caprel_timer
  import caprel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rx_baud,
  output logic              tx_baud
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              rx_q, tx_q, rx_d, tx_d;
  logic              cnt_fall, cnt_lvl, trig_fall, trig_lvl, tick;
  logic              baud, updn, step, trig_evt, core_trig, wrap;
  logic              wr_ctrl, wr_mode;
  logic [CNT_W-1:0]  cnt, cap;
  op_mode_e          op;

  caprel_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall));

  caprel_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .level(trig_lvl), .fall(trig_fall));

  caprel_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN] & ~ctrl_q[B_SRC]),
    .fast(fast_mode), .tick(tick));

  always_comb begin
    baud      = ctrl_q[B_RXS] | ctrl_q[B_TXS];
    updn      = mode_q[M_UPDN];
    if (baud)                op = OP_BAUD;
    else if (updn)           op = OP_UPDOWN;
    else if (ctrl_q[B_CAPT]) op = OP_CAPTURE;
    else                     op = OP_RELOAD;
    step      = ctrl_q[B_RUN] & (ctrl_q[B_SRC] ? cnt_fall : tick);
    trig_evt  = ctrl_q[B_EXEN] & trig_fall;
    core_trig = trig_evt & ~baud & ~updn;
    wr_ctrl   = bus_we && bus_addr == A_CTRL;
    wr_mode   = bus_we && bus_addr == A_MODE;
  end

  caprel_core #(.DW(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(op), .step(step), .dir_up(trig_lvl),
    .trig(core_trig),
    .wr_cnt_lo(bus_we && bus_addr == A_CNT_LO),
    .wr_cnt_hi(bus_we && bus_addr == A_CNT_HI),
    .wr_cap_lo(bus_we && bus_addr == A_CAP_LO),
    .wr_cap_hi(bus_we && bus_addr == A_CAP_HI),
    .wdata(bus_wdata), .cnt(cnt), .cap(cap), .wrap(wrap));

  // next state: hardware flag sets take priority over a software write
  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    if (wr_ctrl) ctrl_d = bus_wdata;
    if (wr_mode) mode_d = bus_wdata[MODE_W-1:0];
    if (wrap && !baud) ctrl_d[B_OVF] = 1'b1;
    if (trig_evt)      ctrl_d[B_EXT] = 1'b1;
    rx_d = wrap & baud & ctrl_q[B_RXS];
    tx_d = wrap & baud & ctrl_q[B_TXS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_q;
      A_MODE:   bus_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
      A_CAP_LO: bus_rdata = cap[DATA_W-1:0];
      A_CAP_HI: bus_rdata = cap[CNT_W-1:DATA_W];
      A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
      default:  bus_rdata = '0;
    endcase
  end

  assign irq     = ctrl_q[B_OVF] | (ctrl_q[B_EXT] & ~mode_q[M_UPDN]);
  assign rx_baud = rx_q;
  assign tx_baud = tx_q;

  // R5: overflow flag only drops on a control write
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_OVF] && !wr_ctrl) |=> ctrl_q[B_OVF]);

  // R9: baud mode never raises the overflow flag
  p_no_ovf_baud_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_q[B_OVF] && !wr_ctrl) |=> !ctrl_q[B_OVF]);

  // R9: a receive pulse follows a counter that was at all-ones
  p_rx_after_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_baud |-> ($past(cnt) == '1));

  // R11: external flag alone cannot interrupt in up/down mode
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[M_UPDN] && !ctrl_q[B_OVF]) |-> !irq);
endmodule

// File: tb/caprel_timer_bench.sv
module caprel_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_mode = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, rx_baud, tx_baud;

  int n_chk = 0;
  int n_bad = 0;
  int rx_n = 0;
  int tx_n = 0;

  always #10 clk = ~clk;

  caprel_timer u_caprel_timer (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_baud(rx_baud), .tx_baud(tx_baud));

  always @(posedge clk) begin
    if (rx_baud) rx_n <= rx_n + 1;
    if (tx_baud) tx_n <= tx_n + 1;
  end

  task automatic check(input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd16(input logic [7:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 8'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 8'd1, d[15:8]);
  endtask

  task automatic cnt_edge();
    @(negedge clk); cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic trig_edge();
    @(negedge clk); trig_pin = 1'b0;
    repeat (3) @(negedge clk);
    trig_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [15:0] w;
    rd(8'hC8, b);  check("R1 control reset", b, 8'h00);
    rd(8'hC9, b);  check("R1 mode reset", b, 8'h00);
    rd16(8'hCC, w); check("R1 counter reset", w, 16'h0000);
    rd16(8'hCA, w); check("R1 capture reset", w, 16'h0000);
    check("R1 irq reset", irq, 0);
    check("R1 baud reset", {rx_baud, tx_baud}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] b; logic [15:0] w;
    wr16(8'hCA, 16'hA55A); rd16(8'hCA, w); check("R2 capture rw", w, 16'hA55A);
    wr16(8'hCC, 16'h3CC3); rd16(8'hCC, w); check("R2 counter rw", w, 16'h3CC3);
    wr(8'hC9, 8'hFE); rd(8'hC9, b); check("R2 mode rw reserved zero", b, 8'h02);
    wr(8'hC9, 8'h00);
    wr(8'hC8, 8'h39); rd(8'hC8, b); check("R2 control rw", b, 8'h39);
    wr(8'hC8, 8'h00);
  endtask

  task automatic t_prescale();
    logic [15:0] w;
    wr16(8'hCC, 16'h0000);
    fast_mode = 1'b0;
    wr(8'hC8, 8'h04);
    repeat (54) @(negedge clk);
    wr(8'hC8, 8'h00);
    rd16(8'hCC, w); check("R3 divide by 12", w, 16'h0004);
    wr16(8'hCC, 16'h0000);
    fast_mode = 1'b1;
    wr(8'hC8, 8'h04);
    repeat (32) @(negedge clk);
    wr(8'hC8, 8'h00);
    fast_mode = 1'b0;
    rd16(8'hCC, w); check("R3 divide by 6", w, 16'h0005);
  endtask

  task automatic t_extcount();
    logic [15:0] w;
    wr16(8'hCC, 16'h0010);
    wr(8'hC8, 8'h06);
    for (int i = 0; i < 7; i++) cnt_edge();
    rd16(8'hCC, w); check("R4 external edges counted", w, 16'h0017);
    wr(8'hC8, 8'h02);
    for (int i = 0; i < 3; i++) cnt_edge();
    rd16(8'hCC, w); check("R4 no count when stopped", w, 16'h0017);
  endtask

  task automatic t_reload();
    logic [7:0] b; logic [15:0] w;
    wr16(8'hCA, 16'h1234);
    wr16(8'hCC, 16'hFFFE);
    wr(8'hC8, 8'h06);
    cnt_edge(); cnt_edge();
    rd16(8'hCC, w); check("R5 overflow reload", w, 16'h1234);
    rd(8'hC8, b); check("R5 overflow flag set", b, 8'h86);
    check("R6 irq on overflow", irq, 1);
    wr(8'hC8, 8'h06);
    rd(8'hC8, b); check("R5 flag cleared by write", b, 8'h06);
    check("R6 irq drops", irq, 0);
    wr(8'hC8, 8'h0E);
    wr16(8'hCC, 16'h0010);
    trig_edge();
    rd16(8'hCC, w); check("R7 trigger reload", w, 16'h1234);
    rd(8'hC8, b); check("R7 external flag", b, 8'h4E);
    check("R11 irq from external flag", irq, 1);
    wr(8'hC8, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] b; logic [15:0] w;
    wr(8'hC8, 8'h09);
    wr16(8'hCC, 16'h0042);
    trig_edge();
    rd16(8'hCA, w); check("R7 capture value", w, 16'h0042);
    rd16(8'hCC, w); check("R7 counter kept", w, 16'h0042);
    rd(8'hC8, b); check("R7 capture flag", b, 8'h49);
    wr(8'hC8, 8'h01);
    wr16(8'hCA, 16'h5555);
    trig_edge();
    rd16(8'hCA, w); check("R8 disabled capture", w, 16'h5555);
    rd(8'hC8, b); check("R8 no flag", b, 8'h01);
    check("R8 no irq", irq, 0);
    wr(8'hC8, 8'h00);
  endtask

  task automatic t_baud();
    logic [7:0] b; logic [15:0] w;
    wr16(8'hCA, 16'hFFFC);
    wr16(8'hCC, 16'hFFFE);
    rx_n = 0; tx_n = 0;
    wr(8'hC8, 8'h26);
    for (int i = 0; i < 6; i++) cnt_edge();
    rd16(8'hCC, w); check("R9 baud reload", w, 16'hFFFC);
    check("R9 rx pulses", rx_n, 2);
    check("R9 tx quiet", tx_n, 0);
    rd(8'hC8, b); check("R9 no overflow flag", b, 8'h26);
    wr(8'hC8, 8'h16);
    cnt_edge(); cnt_edge(); cnt_edge(); cnt_edge();
    check("R9 tx pulse", tx_n, 1);
    check("R9 rx held", rx_n, 2);
    wr(8'hC8, 8'h1B);
    wr16(8'hCC, 16'h0777);
    trig_edge();
    rd16(8'hCA, w); check("R9 trigger no capture", w, 16'hFFFC);
    wr(8'hC8, 8'h00);
  endtask

  task automatic t_updown();
    logic [7:0] b; logic [15:0] w;
    wr(8'hC9, 8'h01);
    wr16(8'hCA, 16'h0100);
    wr16(8'hCC, 16'hFFFF);
    wr(8'hC8, 8'h06);
    cnt_edge();
    rd16(8'hCC, w); check("R10 up wrap", w, 16'h0100);
    rd(8'hC8, b); check("R10 up flag", b, 8'h86);
    wr(8'hC8, 8'h06);
    @(negedge clk); trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    wr16(8'hCC, 16'h0101);
    cnt_edge();
    rd16(8'hCC, w); check("R10 count down", w, 16'h0100);
    cnt_edge();
    rd16(8'hCC, w); check("R10 down wrap", w, 16'hFFFF);
    rd(8'hC8, b); check("R10 down flag", b, 8'h86);
    @(negedge clk); trig_pin = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'hC8, 8'h0A);
    wr16(8'hCC, 16'h0200);
    trig_edge();
    rd16(8'hCC, w); check("R10 trigger no reload", w, 16'h0200);
    rd(8'hC8, b); check("R11 external flag set", b, 8'h4A);
    check("R11 irq masked", irq, 0);
    wr(8'hC9, 8'h00);
    @(negedge clk);
    check("R11 irq unmasked", irq, 1);
    wr(8'hC8, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_prescale();
    t_extcount();
    t_reload();
    t_capture();
    t_baud();
    t_updown();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule